// File: doc/BRIEF.md
# Row/Column Accessible Banked Vector Register File

This block holds the vector registers in eight element-wide banks. Register `r` is stored rotated by `r` positions across the banks, so element `j` of register `r` sits in bank `(j + r) mod 8` at row `r*(VLEN/ELEN/8) + j/8`. Because of the rotation, one cycle can reach either eight consecutive elements of one register (a row) or the same element index in eight consecutive registers (a column). A segment load or store can therefore transpose its fields in place, without a separate staging buffer.

There are two request ports, and each can read or write. The row port names a register and a chunk, which is a group of eight elements. The column port names a base register `r0` and an element index `j`; lane `i` of its data belongs to register `(r0 + i) mod NREG`. Each bank has one write port and one read port. When both request ports want the same kind of bank port in the same cycle, the row port is served and the column request is dropped. Layered power-of-two rotators sit on the write path and on the read path, and they turn bank order back into lane order. Read data is returned one cycle after the request.

Top module: `rc_regfile`

## Requirements
- R1: While reset is high, and in the first cycle after it, `row_rvalid` and `col_rvalid` are 0 and both read data buses are all zero.
- R2: A row read of register `r`, chunk `c` returns element `c*8 + k` of register `r` on lane `k`. Lane `k` occupies bits `[k*ELEN +: ELEN]`. `row_rvalid` is high in the cycle after the request.
- R3: A column write with base `r0` and element `j` stores lane `i` into element `j` of register `(r0 + i) mod NREG`, for i = 0..7, and changes no other element.
- R4: A column read with base `r0` and element `j` returns element `j` of register `(r0 + i) mod NREG` on lane `i`. `col_rvalid` is high in the cycle after the request.
- R5: If a row write and a column write are requested in the same cycle, only the row write is performed. The column write changes no stored element.
- R6: If a row read and a column read are requested in the same cycle, only the row read is performed. `col_rvalid` stays 0 in the following cycle.
- R7: A read returns the contents as they were before any write accepted in the same cycle. The new value is visible from the next request on.
- R8: A row read and a column write can be served in the same cycle, and so can a row write and a column read.
- R9: A `*_rvalid` output is 1 exactly one cycle after an accepted read on its port and 0 otherwise. While it is 0, the matching data bus is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_req_valid | input | 1 | Row request present |
| row_we | input | 1 | Row request is a write (1) or a read (0) |
| row_reg | input | 5 | Register number for the row request |
| row_chunk | input | 1 | Group of eight elements within the register |
| row_wdata | input | 256 | Row write data, lane k = element chunk*8+k |
| row_rvalid | output | 1 | Row read data valid |
| row_rdata | output | 256 | Row read data in lane order |
| col_req_valid | input | 1 | Column request present |
| col_we | input | 1 | Column request is a write (1) or a read (0) |
| col_reg | input | 5 | Base register r0 of the column |
| col_elem | input | 4 | Element index j |
| col_wdata | input | 256 | Column write data, lane i = register r0+i |
| col_rvalid | output | 1 | Column read data valid |
| col_rdata | output | 256 | Column read data in lane order |

## Verification
A read request issued before clock edge N returns its data and valid flag on the outputs just after edge N. A write accepted at edge N affects reads issued from edge N+1 onwards. The bench drives inputs on the falling edge. At each rising edge it computes the expected read results from its element-level model as it stood before that edge, and only then applies the writes that were accepted. It compares all four outputs on the next falling edge, which is exactly one register stage after the request. Requests that collide are issued in the same cycle. Their outcome is seen either in the missing column valid, or in a later row or column read of the affected elements.

// File: rtl/rcrf_pkg.sv
package rcrf_pkg;

  // bit width needed to index v items, never below 1
  function automatic int lg(input int v);
    return (v <= 1) ? 1 : $clog2(v);
  endfunction

  // source of the read data currently held in the banks' output registers
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_ROW  = 2'd1,
    RD_COL  = 2'd2
  } rd_src_e;

endpackage

// File: rtl/rcrf_bank.sv
// One element-wide bank: one write port and one registered read port
// (read-first), written so that it maps onto a simple dual-port block RAM.
module rcrf_bank #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rcrf_rotate.sv
// Block circular shifter built from log2(N) layers of power-of-two moves.
// Output lane k takes input lane (k + amt) mod N.
module rcrf_rotate #(
  parameter int N  = 8,
  parameter int W  = 32,
  parameter int SW = 3
) (
  input  logic [N-1:0][W-1:0] din,
  input  logic [SW-1:0]       amt,
  output logic [N-1:0][W-1:0] dout
);

  always_comb begin
    logic [N-1:0][W-1:0] cur;
    logic [N-1:0][W-1:0] nxt;
    cur = din;
    nxt = din;
    for (int s = 0; s < SW; s++) begin
      for (int k = 0; k < N; k++) begin
        nxt[k] = amt[s] ? cur[(k + (1 << s)) % N] : cur[k];
      end
      cur = nxt;
    end
    dout = cur;
  end

endmodule

// File: rtl/rcrf_colmap.sv
// Per-bank row addresses for a column access (element elem of registers
// base_reg .. base_reg+N-1). Bank b serves lane (b - elem - base_reg) mod N.
module rcrf_colmap import rcrf_pkg::*; #(
  parameter int NBANK = 8,
  parameter int NREG  = 32,
  parameter int EPR   = 16,
  parameter int CPR   = 2
) (
  input  logic [lg(NREG)-1:0]                  base_reg,
  input  logic [lg(EPR)-1:0]                   elem,
  output logic [NBANK-1:0][lg(NREG*CPR)-1:0]   addr
);

  localparam int SW = lg(NBANK);
  localparam int RW = lg(NREG);
  localparam int AW = lg(NREG*CPR);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [SW-1:0] lane;
    logic [RW-1:0] rsel;
    assign lane    = SW'(b) - elem[SW-1:0] - base_reg[SW-1:0];
    assign rsel    = base_reg + RW'(lane);
    assign addr[b] = AW'(rsel * CPR + elem / NBANK);
  end

endmodule

// File: rtl/rc_regfile.sv
module rc_regfile import rcrf_pkg::*; #(
  parameter int NBANK = 8,
  parameter int ELEN  = 32,
  parameter int VLEN  = 512,
  parameter int NREG  = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          row_req_valid,
  input  logic                          row_we,
  input  logic [lg(NREG)-1:0]           row_reg,
  input  logic [lg(VLEN/ELEN/NBANK)-1:0] row_chunk,
  input  logic [NBANK*ELEN-1:0]         row_wdata,
  output logic                          row_rvalid,
  output logic [NBANK*ELEN-1:0]         row_rdata,
  input  logic                          col_req_valid,
  input  logic                          col_we,
  input  logic [lg(NREG)-1:0]           col_reg,
  input  logic [lg(VLEN/ELEN)-1:0]      col_elem,
  input  logic [NBANK*ELEN-1:0]         col_wdata,
  output logic                          col_rvalid,
  output logic [NBANK*ELEN-1:0]         col_rdata
);

  localparam int EPR   = VLEN / ELEN;
  localparam int CPR   = EPR / NBANK;
  localparam int DEPTH = NREG * CPR;
  localparam int AW    = lg(DEPTH);
  localparam int SW    = lg(NBANK);

  typedef logic [NBANK-1:0][ELEN-1:0] lanes_t;

  // ---------------- request arbitration ----------------
  logic wr_row, wr_col, rd_row, rd_col;
  assign wr_row = row_req_valid & row_we;
  assign wr_col = col_req_valid & col_we & ~wr_row;
  assign rd_row = row_req_valid & ~row_we;
  assign rd_col = col_req_valid & ~col_we & ~rd_row;

  // ---------------- addressing ----------------
  logic [AW-1:0]             row_addr;
  logic [NBANK-1:0][AW-1:0]  col_addr;
  logic [SW-1:0]             col_amt;

  assign row_addr = AW'(row_reg * CPR + row_chunk);
  assign col_amt  = col_elem[SW-1:0] + col_reg[SW-1:0];

  rcrf_colmap #(
    .NBANK (NBANK),
    .NREG  (NREG),
    .EPR   (EPR),
    .CPR   (CPR)
  ) u_colmap (
    .base_reg (col_reg),
    .elem     (col_elem),
    .addr     (col_addr)
  );

  // ---------------- write path: lane order -> bank order ----------------
  lanes_t        wr_lanes, wr_banks;
  logic [SW-1:0] wr_amt, wr_unrot;

  assign wr_lanes = wr_row ? lanes_t'(row_wdata) : lanes_t'(col_wdata);
  assign wr_amt   = wr_row ? row_reg[SW-1:0] : col_amt;
  assign wr_unrot = SW'(0) - wr_amt;

  rcrf_rotate #(.N(NBANK), .W(ELEN), .SW(SW)) u_wr_rot (
    .din  (wr_lanes),
    .amt  (wr_unrot),
    .dout (wr_banks)
  );

  // ---------------- banks ----------------
  lanes_t bank_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rcrf_bank #(.W(ELEN), .DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk   (clk),
      .we    (wr_row | wr_col),
      .waddr (wr_row ? row_addr : col_addr[b]),
      .wdata (wr_banks[b]),
      .re    (rd_row | rd_col),
      .raddr (rd_row ? row_addr : col_addr[b]),
      .rdata (bank_q[b])
    );
  end

  // ---------------- read path: bank order -> lane order ----------------
  rd_src_e       rd_src;
  logic [SW-1:0] rd_amt;
  lanes_t        rd_lanes;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_src <= RD_NONE;
      rd_amt <= '0;
    end else begin
      rd_src <= rd_row ? RD_ROW : (rd_col ? RD_COL : RD_NONE);
      if (rd_row | rd_col) rd_amt <= rd_row ? row_reg[SW-1:0] : col_amt;
    end
  end

  rcrf_rotate #(.N(NBANK), .W(ELEN), .SW(SW)) u_rd_rot (
    .din  (bank_q),
    .amt  (rd_amt),
    .dout (rd_lanes)
  );

  assign row_rvalid = (rd_src == RD_ROW);
  assign col_rvalid = (rd_src == RD_COL);
  assign row_rdata  = row_rvalid ? rd_lanes : '0;
  assign col_rdata  = col_rvalid ? rd_lanes : '0;

  // ---------------- assertions ----------------
  // R2
  row_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (row_req_valid && !row_we) |=> row_rvalid);

  // R9
  row_src_chk: assert property (@(posedge clk) disable iff (rst)
    row_rvalid |-> $past(row_req_valid && !row_we));

  // R9
  col_src_chk: assert property (@(posedge clk) disable iff (rst)
    col_rvalid |-> $past(col_req_valid && !col_we));

  // R6
  col_yield_chk: assert property (@(posedge clk) disable iff (rst)
    col_rvalid |-> !$past(row_req_valid && !row_we));

  // R4
  col_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (col_req_valid && !col_we && !(row_req_valid && !row_we)) |=> col_rvalid);

  // R6
  one_reader_chk: assert property (@(posedge clk) disable iff (rst)
    !(row_rvalid && col_rvalid));

  // R9
  row_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !row_rvalid |-> (row_rdata == '0));

  // R9
  col_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !col_rvalid |-> (col_rdata == '0));

endmodule

// File: tb/rc_regfile_tb.sv
module rc_regfile_tb;

  localparam int NBANK = 8;
  localparam int ELEN  = 32;
  localparam int VLEN  = 512;
  localparam int NREG  = 32;
  localparam int EPR   = VLEN / ELEN;
  localparam int CPR   = EPR / NBANK;
  localparam int DW    = NBANK * ELEN;
  localparam int RW    = 5;
  localparam int CW    = 1;
  localparam int EW    = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic          row_req_valid, row_we;
  logic [RW-1:0] row_reg;
  logic [CW-1:0] row_chunk;
  logic [DW-1:0] row_wdata;
  logic          row_rvalid;
  logic [DW-1:0] row_rdata;
  logic          col_req_valid, col_we;
  logic [RW-1:0] col_reg;
  logic [EW-1:0] col_elem;
  logic [DW-1:0] col_wdata;
  logic          col_rvalid;
  logic [DW-1:0] col_rdata;

  rc_regfile #(.NBANK(NBANK), .ELEN(ELEN), .VLEN(VLEN), .NREG(NREG)) u_dut (
    .clk(clk), .rst(rst),
    .row_req_valid(row_req_valid), .row_we(row_we), .row_reg(row_reg),
    .row_chunk(row_chunk), .row_wdata(row_wdata),
    .row_rvalid(row_rvalid), .row_rdata(row_rdata),
    .col_req_valid(col_req_valid), .col_we(col_we), .col_reg(col_reg),
    .col_elem(col_elem), .col_wdata(col_wdata),
    .col_rvalid(col_rvalid), .col_rdata(col_rdata)
  );

  // element-level reference model
  logic [ELEN-1:0] mdl [NREG][EPR];

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string phase  = "R1";

  function automatic logic [DW-1:0] mdl_row(int r, int c);
    logic [DW-1:0] v;
    for (int k = 0; k < NBANK; k++) v[k*ELEN +: ELEN] = mdl[r][c*NBANK + k];
    return v;
  endfunction

  function automatic logic [DW-1:0] mdl_col(int r0, int j);
    logic [DW-1:0] v;
    for (int i = 0; i < NBANK; i++) v[i*ELEN +: ELEN] = mdl[(r0 + i) % NREG][j];
    return v;
  endfunction

  function automatic logic [DW-1:0] rnd_word();
    logic [DW-1:0] v;
    for (int k = 0; k < NBANK; k++) v[k*ELEN +: ELEN] = $urandom;
    return v;
  endfunction

  task automatic chk_bus(string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL [%s] %s got %h exp %h", phase, what, got, exp);
    end
  endtask

  task automatic chk_bit(string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL [%s] %s got %b exp %b", phase, what, got, exp);
    end
  endtask

  // drive one cycle of requests, update the model at the edge, compare after it
  task automatic cyc(input bit rq, input bit rwe, input int rr, input int rc,
                     input logic [DW-1:0] rwd,
                     input bit cq, input bit cwe, input int cr, input int ce,
                     input logic [DW-1:0] cwd);
    bit            erv, ecv, do_rw, do_cw;
    logic [DW-1:0] erd, ecd;
    row_req_valid = rq;  row_we = rwe;
    row_reg = rr[RW-1:0]; row_chunk = rc[CW-1:0]; row_wdata = rwd;
    col_req_valid = cq;  col_we = cwe;
    col_reg = cr[RW-1:0]; col_elem = ce[EW-1:0]; col_wdata = cwd;
    @(posedge clk);
    do_rw = rq && rwe;
    do_cw = cq && cwe && !do_rw;
    erv   = rq && !rwe;
    ecv   = cq && !cwe && !erv;
    erd   = erv ? mdl_row(rr, rc) : '0;
    ecd   = ecv ? mdl_col(cr, ce) : '0;
    if (do_rw)
      for (int k = 0; k < NBANK; k++) mdl[rr][rc*NBANK + k] = rwd[k*ELEN +: ELEN];
    if (do_cw)
      for (int i = 0; i < NBANK; i++) mdl[(cr + i) % NREG][ce] = cwd[i*ELEN +: ELEN];
    @(negedge clk);
    chk_bit("R9 row_rvalid", row_rvalid, erv);
    chk_bus("R2 row_rdata", row_rdata, erd);
    chk_bit("R9 col_rvalid", col_rvalid, ecv);
    chk_bus("R4 col_rdata", col_rdata, ecd);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, '0, 0, 0, 0, 0, '0);
  endtask

  task automatic row_rd(int r, int c);
    cyc(1, 0, r, c, '0, 0, 0, 0, 0, '0);
  endtask

  task automatic col_rd(int r0, int j);
    cyc(0, 0, 0, 0, '0, 1, 0, r0, j, '0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL [watchdog] R9 run end got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    row_req_valid = 0; row_we = 0; row_reg = '0; row_chunk = '0; row_wdata = '0;
    col_req_valid = 0; col_we = 0; col_reg = '0; col_elem = '0; col_wdata = '0;
    repeat (4) @(negedge clk);
    phase = "R1 reset";
    chk_bit("R1 row_rvalid", row_rvalid, 1'b0);
    chk_bus("R1 row_rdata", row_rdata, '0);
    chk_bit("R1 col_rvalid", col_rvalid, 1'b0);
    chk_bus("R1 col_rdata", col_rdata, '0);
    rst = 1'b0;
    idle();

    phase = "R2 fill by rows";
    for (int r = 0; r < NREG; r++)
      for (int c = 0; c < CPR; c++)
        cyc(1, 1, r, c, rnd_word(), 0, 0, 0, 0, '0);

    phase = "R2 row readback";
    for (int r = 0; r < NREG; r++)
      for (int c = 0; c < CPR; c++)
        row_rd(r, c);

    phase = "R4 column read sweep";
    for (int r0 = 0; r0 < NREG; r0 += 3)
      for (int j = 0; j < EPR; j++)
        col_rd(r0, j);

    phase = "R3 column write";
    foreach (mdl[r]) begin
      if (r % 5 == 0 || r == 28 || r == 31)
        for (int j = 0; j < EPR; j += 3)
          cyc(0, 0, 0, 0, '0, 1, 1, r, j, rnd_word());
    end
    phase = "R3 row readback after column writes";
    for (int r = 0; r < NREG; r++)
      for (int c = 0; c < CPR; c++)
        row_rd(r, c);
    phase = "R3 column readback with wrap";
    for (int j = 0; j < EPR; j++) col_rd(28, j);
    col_rd(31, 15);

    phase = "R5 row write beats column write";
    cyc(1, 1, 4, 0, rnd_word(), 1, 1, 0, 4, rnd_word());
    cyc(1, 1, 10, 1, rnd_word(), 1, 1, 20, 3, rnd_word());
    row_rd(4, 0);
    col_rd(0, 4);
    for (int i = 0; i < NBANK; i++) row_rd(20 + i, 0);
    col_rd(20, 3);

    phase = "R6 row read beats column read";
    cyc(1, 0, 7, 1, '0, 1, 0, 3, 9, '0);
    cyc(1, 0, 0, 0, '0, 1, 0, 0, 0, '0);
    idle();

    phase = "R7 R8 read old data during write";
    cyc(1, 0, 6, 1, '0, 1, 1, 2, 9, rnd_word());
    row_rd(6, 1);
    cyc(1, 1, 9, 0, rnd_word(), 1, 0, 5, 2, '0);
    col_rd(5, 2);
    cyc(1, 0, 30, 0, '0, 1, 1, 30, 0, rnd_word());
    cyc(1, 0, 30, 0, '0, 1, 1, 27, 3, rnd_word());
    col_rd(27, 3);

    phase = "R9 random mix";
    for (int n = 0; n < 1500; n++) begin
      cyc($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, NREG-1),
          $urandom_range(0, CPR-1), rnd_word(),
          $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, NREG-1),
          $urandom_range(0, EPR-1), rnd_word());
    end
    idle();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule